// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the test access port of a chip. It runs the sixteen-state TAP state machine from TCK and TMS. It holds a 3-bit instruction register and decodes the current instruction. It routes TDO from whichever test data register the instruction selects. The bypass bit and a 32-bit device identification register live inside the block. The boundary register does not: its cells sit at the pads and take TDI directly. Their serial output comes back on `bsr_so_i`, and the block drives their capture, shift and update strobes and the mode lines (external test, clamp, sample/preload).

The port is only active while `dbg_mode_i` is low. While that pin is high, the machine is held in Test-Logic-Reset on every rising TCK edge, which leaves the chip free for other uses of the test pins. The state machine and all shift registers change on the rising edge of TCK. The instruction register and TDO change on the falling edge. TCK may be stopped at either level, and all state is kept while it is stopped.

Top module: `tap_ctrl`

## Requirements
- R1: The state machine follows the standard 16-state TAP graph on each rising TCK edge, steered by TMS, including the Pause and Exit2 loops. A data scan split by a pause delivers the same bits as an unbroken scan.
- R2: Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. In that state the current instruction becomes IDCODE (011) and TDO is disabled.
- R3: `rst_ni` low, with no clock edge needed, forces Test-Logic-Reset, sets IDCODE (011) as the current instruction, and clears `tdo_o` and `tdo_oe_o`.
- R4: In Capture-IR the instruction shift register loads 001. It shifts in Shift-IR with TDI entering at the MSB and bit 0 appearing on TDO first. Its contents become the current instruction on the falling TCK edge in Update-IR, and at no other time except reset.
- R5: The opcodes are 111 bypass, 001 external test, 100 sample/preload, 010 clamp and 011 IDCODE. `extest_o`, `sample_o` and `clamp_o` are each high only while their own opcode is current. All other codes act as bypass with every mode line low.
- R6: Under bypass, clamp or an unlisted opcode, the 1-bit bypass register sits between TDI and TDO. It captures 0, so a scan returns 0 followed by the TDI bits delayed by one cycle.
- R7: Under IDCODE, Capture-DR loads the 32-bit value {version[3:0], part[15:0], maker[10:0], 1}, which then shifts out LSB first.
- R8: Under external test or sample/preload, TDO follows `bsr_so_i`. `bsr_capture_o`, `bsr_shift_o` and `bsr_update_o` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while the boundary register is selected.
- R9: TDO and its enable change only on the falling TCK edge. `tdo_oe_o` is high only during Shift-IR and Shift-DR, and `tdo_o` is 0 whenever `tdo_oe_o` is low.
- R10: While `dbg_mode_i` is high, every rising TCK edge forces Test-Logic-Reset, so no scan can start and IDCODE stays current.
- R11: Stopping TCK high or low for any time changes no output, and a scan continues correctly once the clock resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial test data in |
| dbg_mode_i | input | 1 | High: port held in reset (not compliant); low: TAP active |
| bsr_so_i | input | 1 | Serial return from the external boundary register |
| tdo_o | output | 1 | Serial test data out, changes on the falling edge |
| tdo_oe_o | output | 1 | TDO driver enable |
| extest_o | output | 1 | External test instruction current |
| clamp_o | output | 1 | Clamp instruction current |
| sample_o | output | 1 | Sample/preload instruction current |
| bsr_capture_o | output | 1 | Boundary capture strobe |
| bsr_shift_o | output | 1 | Boundary shift strobe |
| bsr_update_o | output | 1 | Boundary update strobe |

## Verification
The bench tests every listed opcode. It also tests one unlisted code, which tells apart the bypass fallback and the register that each code selects. Data scans use asymmetric bit patterns such as A5, 3C and 81, so a missing captured zero or an off-by-one delay shows up as a wrong byte. The device ID is read in an unbroken scan and in a scan split by a double pause. Comparing the two shows whether Pause and Exit2 keep the shifted state. Exits to reset use three routes: five TMS-high edges from mid-shift, the asynchronous reset pin, and the compliance pin. Each exit is followed by a fresh ID read, which confirms that IDCODE came back.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int unsigned IR_W = 3;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_DEVID, DR_BOUNDARY} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b001;
  localparam logic [IR_W-1:0] OP_CLAMP   = 3'b010;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b011;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      TS_RESET:  n = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   n = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: n = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: n = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  n = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: n = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: n = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: n = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: n = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: n = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: n = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  n = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: n = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: n = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: n = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: n = tms ? TS_SEL_DR : TS_IDLE;
      default:   n = TS_RESET;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  input  logic       hold_rst_i,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= TS_RESET;
    else if (hold_rst_i) state_q <= TS_RESET;
    else                 state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic            so_o,
  output logic [IR_W-1:0] ir_o,
  output dr_sel_e         sel_o,
  output logic            extest_o,
  output logic            clamp_o,
  output logic            sample_o
);
  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= IR_CAPTURE;
    else if (state_i == TS_CAP_IR) sr_q <= IR_CAPTURE;
    else if (state_i == TS_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  // current instruction moves on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   ir_q <= OP_IDCODE;
    else if (state_i == TS_RESET)  ir_q <= OP_IDCODE;
    else if (state_i == TS_UPD_IR) ir_q <= sr_q;
  end

  always_comb begin
    sel_o    = DR_BYPASS;
    extest_o = 1'b0;
    clamp_o  = 1'b0;
    sample_o = 1'b0;
    case (ir_q)
      OP_EXTEST: begin sel_o = DR_BOUNDARY; extest_o = 1'b1; end
      OP_SAMPLE: begin sel_o = DR_BOUNDARY; sample_o = 1'b1; end
      OP_CLAMP:  begin sel_o = DR_BYPASS;   clamp_o  = 1'b1; end
      OP_IDCODE: sel_o = DR_DEVID;
      OP_BYPASS: sel_o = DR_BYPASS;
      default:   sel_o = DR_BYPASS;
    endcase
  end

  assign so_o = sr_q[0];
  assign ir_o = ir_q;
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  input  dr_sel_e    sel_i,
  input  logic       bsr_so_i,
  output logic       so_o
);
  localparam int unsigned ID_W = $bits(ID_VALUE);

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            id_sel;

  assign id_sel = (sel_i == DR_DEVID);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   byp_q <= 1'b0;
    else if (state_i == TS_CAP_DR) byp_q <= 1'b0;
    else if (state_i == TS_SH_DR)  byp_q <= tdi_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                             id_q <= '0;
    else if (id_sel && state_i == TS_CAP_DR) id_q <= ID_VALUE;
    else if (id_sel && state_i == TS_SH_DR)  id_q <= {tdi_i, id_q[ID_W-1:1]};
  end

  always_comb begin
    case (sel_i)
      DR_DEVID:    so_o = id_q[0];
      DR_BOUNDARY: so_o = bsr_so_i;
      default:     so_o = byp_q;
    endcase
  end
endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h3A5C,
  parameter logic [10:0] ID_MAKER   = 11'h2B7
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  input  logic dbg_mode_i,
  input  logic bsr_so_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic extest_o,
  output logic clamp_o,
  output logic sample_o,
  output logic bsr_capture_o,
  output logic bsr_shift_o,
  output logic bsr_update_o
);
  localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_state_e      state_q;
  dr_sel_e         dr_sel;
  logic [IR_W-1:0] cur_ir;
  logic            ir_so, dr_so;
  logic            sh_ir, sh_dr, bsr_sel;
  logic            tdo_d, tdo_q, oe_q;

  tap_fsm u_fsm (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .tms_i      (tms_i),
    .hold_rst_i (dbg_mode_i),
    .state_o    (state_q)
  );

  tap_ir u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state_q),
    .so_o     (ir_so),
    .ir_o     (cur_ir),
    .sel_o    (dr_sel),
    .extest_o (extest_o),
    .clamp_o  (clamp_o),
    .sample_o (sample_o)
  );

  tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state_q),
    .sel_i    (dr_sel),
    .bsr_so_i (bsr_so_i),
    .so_o     (dr_so)
  );

  assign sh_ir   = (state_q == TS_SH_IR);
  assign sh_dr   = (state_q == TS_SH_DR);
  assign bsr_sel = (dr_sel == DR_BOUNDARY);

  always_comb begin
    if (sh_ir)      tdo_d = ir_so;
    else if (sh_dr) tdo_d = dr_so;
    else            tdo_d = 1'b0;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= sh_ir | sh_dr;
    end
  end

  assign tdo_o         = tdo_q;
  assign tdo_oe_o      = oe_q;
  assign bsr_capture_o = bsr_sel && (state_q == TS_CAP_DR);
  assign bsr_shift_o   = bsr_sel && sh_dr;
  assign bsr_update_o  = bsr_sel && (state_q == TS_UPD_DR);
endmodule

// File: rtl/tap_ctrl_chk.sv
`timescale 1ns/1ps
module tap_ctrl_chk
  import tap_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input logic            dbg_mode_i,
  input tap_state_e      state_i,
  input logic [IR_W-1:0] ir_i,
  input logic            tdo_o,
  input logic            tdo_oe_o,
  input logic            extest_o,
  input logic            clamp_o,
  input logic            sample_o,
  input logic            bsr_capture_o,
  input logic            bsr_shift_o,
  input logic            bsr_update_o
);
  logic [2:0] tms_run_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)           tms_run_q <= '0;
    else if (!tms_i)       tms_run_q <= '0;
    else if (tms_run_q < 3'd5) tms_run_q <= tms_run_q + 3'd1;
  end

  a_r2_five_tms_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_run_q >= 3'd5) |-> (state_i == TS_RESET));

  a_r4_ir_stable: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i == TS_UPD_IR || state_i == TS_RESET) |-> $stable(ir_i));

  a_r5_modes_exclusive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({extest_o, clamp_o, sample_o}));

  a_r8_strobes_exclusive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o}));

  a_r8_shift_needs_boundary: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bsr_shift_o |-> (extest_o || sample_o));

  a_r9_tdo_quiet: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_oe_o |-> !tdo_o);

  a_r10_hold_in_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    dbg_mode_i |=> (state_i == TS_RESET));
endmodule

bind tap_ctrl tap_ctrl_chk u_tap_ctrl_chk (
  .tck_i         (tck_i),
  .rst_ni        (rst_ni),
  .tms_i         (tms_i),
  .dbg_mode_i    (dbg_mode_i),
  .state_i       (state_q),
  .ir_i          (cur_ir),
  .tdo_o         (tdo_o),
  .tdo_oe_o      (tdo_oe_o),
  .extest_o      (extest_o),
  .clamp_o       (clamp_o),
  .sample_o      (sample_o),
  .bsr_capture_o (bsr_capture_o),
  .bsr_shift_o   (bsr_shift_o),
  .bsr_update_o  (bsr_update_o)
);

// File: tb/tap_ctrl_bench.sv
`timescale 1ns/1ps
module tap_ctrl_bench;
  localparam logic [3:0]  VER   = 4'h1;
  localparam logic [15:0] PART  = 16'h3A5C;
  localparam logic [10:0] MAKER = 11'h2B7;
  localparam logic [31:0] EXP_ID = {VER, PART, MAKER, 1'b1};

  logic tck_i = 1'b0;
  bit   run = 1'b1;
  logic rst_ni, tms_i, tdi_i, dbg_mode_i, bsr_so_i;
  logic tdo_o, tdo_oe_o, extest_o, clamp_o, sample_o;
  logic bsr_capture_o, bsr_shift_o, bsr_update_o;

  int checks = 0;
  int errors = 0;

  always begin
    #2.5;
    if (run) tck_i = ~tck_i;
  end

  tap_ctrl #(.ID_VERSION(VER), .ID_PART(PART), .ID_MAKER(MAKER)) u_tap_ctrl (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .dbg_mode_i(dbg_mode_i), .bsr_so_i(bsr_so_i),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o),
    .extest_o(extest_o), .clamp_o(clamp_o), .sample_o(sample_o),
    .bsr_capture_o(bsr_capture_o), .bsr_shift_o(bsr_shift_o), .bsr_update_o(bsr_update_o)
  );

  // reference model: states numbered 0 reset,1 idle,2..8 DR column,9..15 IR column
  int         m_state;
  logic [2:0] m_irsr, m_ir;
  logic       m_byp, m_tdo, m_oe;
  logic [31:0] m_idsr;

  function automatic int m_next(input int s, input logic t);
    case (s)
      0:  return t ? 0 : 1;
      1:  return t ? 2 : 1;
      2:  return t ? 9 : 3;
      3:  return t ? 5 : 4;
      4:  return t ? 5 : 4;
      5:  return t ? 8 : 6;
      6:  return t ? 7 : 6;
      7:  return t ? 8 : 4;
      8:  return t ? 2 : 1;
      9:  return t ? 0 : 10;
      10: return t ? 12 : 11;
      11: return t ? 12 : 11;
      12: return t ? 15 : 13;
      13: return t ? 14 : 13;
      14: return t ? 15 : 11;
      default: return t ? 2 : 1;
    endcase
  endfunction

  function automatic bit m_bsr();
    return (m_ir == 3'b001) || (m_ir == 3'b100);
  endfunction

  task automatic model_reset();
    m_state = 0; m_irsr = 3'b001; m_ir = 3'b011;
    m_byp = 1'b0; m_idsr = '0; m_tdo = 1'b0; m_oe = 1'b0;
  endtask

  task automatic model_pos(input logic t, input logic d);
    if (m_state == 10)      m_irsr = 3'b001;
    else if (m_state == 11) m_irsr = {d, m_irsr[2:1]};
    if (m_state == 3) begin
      m_byp = 1'b0;
      if (m_ir == 3'b011) m_idsr = EXP_ID;
    end else if (m_state == 4) begin
      m_byp = d;
      if (m_ir == 3'b011) m_idsr = {d, m_idsr[31:1]};
    end
    m_state = dbg_mode_i ? 0 : m_next(m_state, t);
  endtask

  task automatic model_neg();
    m_oe = (m_state == 11) || (m_state == 4);
    if (m_state == 11)          m_tdo = m_irsr[0];
    else if (m_state == 4) begin
      if (m_ir == 3'b011)       m_tdo = m_idsr[0];
      else if (m_bsr())         m_tdo = bsr_so_i;
      else                      m_tdo = m_byp;
    end else                    m_tdo = 1'b0;
    if (m_state == 15)      m_ir = m_irsr;
    else if (m_state == 0)  m_ir = 3'b011;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R9", "tdo_oe", 32'(tdo_oe_o), 32'(m_oe));
    chk("R9", "tdo", 32'(tdo_o), 32'(m_tdo));
    chk("R5", "extest_o", 32'(extest_o), 32'(m_ir == 3'b001));
    chk("R5", "clamp_o", 32'(clamp_o), 32'(m_ir == 3'b010));
    chk("R5", "sample_o", 32'(sample_o), 32'(m_ir == 3'b100));
    chk("R8", "capture", 32'(bsr_capture_o), 32'(m_bsr() && m_state == 3));
    chk("R8", "shift", 32'(bsr_shift_o), 32'(m_bsr() && m_state == 4));
    chk("R8", "update", 32'(bsr_update_o), 32'(m_bsr() && m_state == 8));
  endtask

  task automatic tick(input logic t, input logic d);
    logic prev;
    tms_i = t; tdi_i = d;
    @(posedge tck_i);
    prev = tdo_o;
    model_pos(t, d);
    #1;
    chk("R9", "tdo held past rising edge", 32'(tdo_o), 32'(prev));
    @(negedge tck_i);
    model_neg();
    #1;
    cmp_all();
  endtask

  // one shift cycle with TCK parked high (R11)
  task automatic tick_hold(input logic t, input logic d);
    logic prev;
    tms_i = t; tdi_i = d;
    @(posedge tck_i);
    prev = tdo_o;
    model_pos(t, d);
    #1 run = 1'b0;
    #40;
    chk("R11", "tck parked high", 32'(tck_i), 32'd1);
    chk("R11", "tdo while parked high", 32'(tdo_o), 32'(prev));
    run = 1'b1;
    @(negedge tck_i);
    model_neg();
    #1;
    cmp_all();
  endtask

  task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    cap[0] = tdo_o;
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i]);
      if (i < 2) cap[i+1] = tdo_o;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    dout[0] = tdo_o;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo_o;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #300000;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [2:0]  c;
    rst_ni = 1'b0; tms_i = 1'b1; tdi_i = 1'b0; dbg_mode_i = 1'b0; bsr_so_i = 1'b0;
    model_reset();
    #12;
    cmp_all();
    chk("R3", "oe in reset", 32'(tdo_oe_o), 32'd0);
    @(negedge tck_i); #1 rst_ni = 1'b1;
    tick(0, 0);

    shift_dr(32, 64'd0, d);
    chk("R7", "id after reset", d[31:0], EXP_ID);

    shift_ir(3'b111, c);
    chk("R4", "ir capture pattern", 32'(c), 32'b001);
    shift_dr(8, 64'hA5, d);
    chk("R6", "bypass A5", d[7:0], 32'h4A);

    shift_ir(3'b010, c);
    chk("R5", "clamp_o on", 32'(clamp_o), 32'd1);
    shift_dr(8, 64'h3C, d);
    chk("R6", "clamp bypass 3C", d[7:0], 32'h78);

    shift_ir(3'b001, c);
    chk("R5", "extest_o on", 32'(extest_o), 32'd1);
    bsr_so_i = 1'b1;
    shift_dr(8, 64'h00, d);
    chk("R8", "boundary return", d[7:0], 32'hFF);
    bsr_so_i = 1'b0;

    shift_ir(3'b100, c);
    chk("R5", "sample_o on", 32'(sample_o), 32'd1);
    bsr_so_i = 1'b1;
    shift_dr(4, 64'h0, d);
    chk("R8", "sample return", d[3:0], 32'hF);
    bsr_so_i = 1'b0;

    shift_ir(3'b101, c);
    chk("R5", "unlisted code modes", 32'({extest_o, clamp_o, sample_o}), 32'd0);
    shift_dr(8, 64'h81, d);
    chk("R6", "unlisted bypass 81", d[7:0], 32'h02);

    // R1: scan split by pause
    shift_ir(3'b011, c);
    d = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    d[0] = tdo_o;
    for (int i = 0; i < 16; i++) begin
      tick(i == 15, 0);
      if (i < 15) d[i+1] = tdo_o;
    end
    tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    d[16] = tdo_o;
    for (int i = 0; i < 16; i++) begin
      tick(i == 15, 0);
      if (i < 15) d[17+i] = tdo_o;
    end
    tick(1, 0); tick(0, 0);
    chk("R1", "id through pause", d[31:0], EXP_ID);

    // R11: clock parked low then high mid scan
    tick(1, 0); tick(0, 0); tick(0, 0);
    d[0] = tdo_o;
    run = 1'b0;
    #40;
    chk("R11", "tdo while parked low", 32'(tdo_o), 32'(EXP_ID[0]));
    chk("R11", "oe while parked low", 32'(tdo_oe_o), 32'd1);
    run = 1'b1;
    tick_hold(0, 0);
    chk("R11", "next id bit after stops", 32'(tdo_o), 32'(EXP_ID[1]));
    tick(1, 0); tick(1, 0); tick(0, 0);

    // R2: five TMS-high edges from mid shift
    shift_ir(3'b001, c);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk("R2", "extest cleared", 32'(extest_o), 32'd0);
    chk("R2", "oe off", 32'(tdo_oe_o), 32'd0);
    tick(0, 0);
    shift_dr(32, 64'd0, d);
    chk("R2", "id after tms reset", d[31:0], EXP_ID);

    // R10: compliance pin high
    shift_ir(3'b001, c);
    dbg_mode_i = 1'b1;
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 0);
    chk("R10", "no scan while held", 32'(tdo_oe_o), 32'd0);
    chk("R10", "idcode restored", 32'(extest_o), 32'd0);
    dbg_mode_i = 1'b0;
    tick(0, 0);
    shift_dr(32, 64'd0, d);
    chk("R10", "id after release", d[31:0], EXP_ID);

    // R3: asynchronous reset mid shift
    shift_ir(3'b001, c);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R3", "oe before reset", 32'(tdo_oe_o), 32'd1);
    #0.5 rst_ni = 1'b0;
    model_reset();
    #0.5;
    chk("R3", "oe cleared async", 32'(tdo_oe_o), 32'd0);
    chk("R3", "extest cleared async", 32'(extest_o), 32'd0);
    cmp_all();
    @(negedge tck_i); #1 rst_ni = 1'b1;
    tick(0, 0);
    shift_dr(32, 64'd0, d);
    chk("R3", "id after async reset", d[31:0], EXP_ID);

    finish_run();
  end
endmodule